// File: doc/BRIEF.md
# Windowed Multi-Quantity Acceptance Flag

This block turns a handful of signed fixed-point quantities into one accept bit. Each quantity is checked against one or more open intervals, expressed in that quantity's own integer units. A quantity passes when it sits inside any of its enabled intervals, and the accept bit is high only when every quantity passes.

The quantities come from an upstream datapath where they become valid at different pipeline stages. Each one is therefore sent through a delay line so that it lines up with the stage where the flag is taken. The length of each line is the evaluation stage minus the stage that produced the quantity. A quantity marked as constant skips the delay line and is used as driven. The flag itself is combinational from the aligned values. If a configuration asks for a negative delay, elaboration stops with an error.

Interval limits are given in physical units together with an integer scale factor per quantity. The block divides them at elaboration, truncating toward zero, so the run-time comparators work directly on the raw quantity codes.

Top module: `wcut_flag`

## Requirements
- R1: A quantity passes an enabled interval only when its value is strictly above the lower limit and strictly below the upper limit; a value equal to either limit does not pass.
- R2: Each native limit equals the physical limit divided by the quantity's scale factor, truncated toward zero. Defaults: quantity 0 (scale 4) has physical intervals (-400,400) and (1000,1200), giving (-100,100) and (250,300); quantity 1 (scale 3) has (-100,200), giving (-33,66); quantity 2 (scale 1) has (0,50).
- R3: Within one quantity, the enabled intervals are OR-combined, and a disabled interval never passes. By default, quantity 0 has both intervals enabled, and quantities 1 and 2 have only their first.
- R4: `flag_o` is the AND of the pass results of all quantities.
- R5: A non-constant quantity is delayed by FLAG_STAGE minus its source stage. Defaults: FLAG_STAGE is 4, quantity 0 comes from stage 1 and is delayed 3 cycles, and quantity 1 comes from stage 3 and is delayed 1 cycle. Quantity q occupies bits [12q+11:12q] of `q_in`.
- R6: A quantity marked constant has no delay line and is used in the same cycle it is driven. By default, quantity 2 is constant.
- R7: `flag_o` has no register after the aligned values, so a change on a constant quantity reaches `flag_o` without a clock edge.
- R8: A synchronous active-high reset clears every delay-line stage to zero. Inputs taken while reset is high enter the lines as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the delay lines |
| q_in | input | NQ*W (36) | Packed signed quantities, quantity q in bits [W*q+W-1:W*q] |
| flag_o | output | 1 | Accept flag, high when all quantities pass |

## Verification
A delay line of the wrong length shows up as a flag that responds to a one-cycle disturbance on the wrong cycle. The bench drives single-cycle out-of-window pulses and compares the flag on every cycle, so this error is visible within the delay depth plus one cycle. A mis-rounded or non-strict limit flips the flag only for a value that sits exactly on the edge or one code inside it, so those codes are driven for every limit. A stage that was not cleared by reset reaches the port on the first cycles after reset is released, as a flag that disagrees with the all-zero history.

// File: rtl/wcut_pkg.sv
package wcut_pkg;
  localparam int LIM_W   = 32;
  localparam int STAGE_W = 8;

  // physical limit to native code, truncating toward zero (int division)
  function automatic int native_bound(input int phys, input int scale);
    return phys / scale;
  endfunction
endpackage

// File: rtl/wcut_delay_line.sv
module wcut_delay_line #(
  parameter int W     = 12,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) stg[k] <= '0;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < DEPTH; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[DEPTH-1];
endmodule

// File: rtl/wcut_window_test.sv
module wcut_window_test
  import wcut_pkg::*;
#(
  parameter int                 W     = 12,
  parameter int                 NW    = 2,
  parameter int                 SCALE = 1,
  parameter logic [NW-1:0]      EN    = '1,
  parameter logic [NW*32-1:0]   LO    = '0,
  parameter logic [NW*32-1:0]   HI    = '0
) (
  input  logic [W-1:0] val,
  output logic         pass
);
  logic [NW-1:0] hit;

  for (genvar w = 0; w < NW; w++) begin : g_win
    if (EN[w]) begin : g_on
      localparam int NLO = native_bound($signed(LO[w*LIM_W +: LIM_W]), SCALE);
      localparam int NHI = native_bound($signed(HI[w*LIM_W +: LIM_W]), SCALE);
      assign hit[w] = ($signed(val) > NLO) && ($signed(val) < NHI);
    end else begin : g_off
      assign hit[w] = 1'b0;
    end
  end

  assign pass = |hit;
endmodule

// File: rtl/wcut_flag.sv
module wcut_flag
  import wcut_pkg::*;
#(
  parameter int                  NQ         = 3,
  parameter int                  NW         = 2,
  parameter int                  W          = 12,
  parameter int                  FLAG_STAGE = 4,
  parameter logic [NQ*8-1:0]     SRC_STAGE  = {8'd2, 8'd3, 8'd1},
  parameter logic [NQ-1:0]       Q_CONST    = 3'b100,
  parameter logic [NQ*32-1:0]    SCALE      = {32'd1, 32'd3, 32'd4},
  parameter logic [NQ*NW-1:0]    WIN_EN     = 6'b01_01_11,
  parameter logic [NQ*NW*32-1:0] LO_PHYS    = {32'sd0, 32'sd0, 32'sd0, -32'sd100, 32'sd1000, -32'sd400},
  parameter logic [NQ*NW*32-1:0] HI_PHYS    = {32'sd0, 32'sd50, 32'sd0, 32'sd200, 32'sd1200, 32'sd400}
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NQ*W-1:0] q_in,
  output logic          flag_o
);
  localparam int QBUS = NQ * W;

  logic [QBUS-1:0] q_aln;
  logic [NQ-1:0]   q_pass;

  for (genvar i = 0; i < NQ; i++) begin : g_q
    localparam int DLY = FLAG_STAGE - int'(SRC_STAGE[i*STAGE_W +: STAGE_W]);

    if (Q_CONST[i]) begin : g_const
      assign q_aln[i*W +: W] = q_in[i*W +: W];
    end else if (DLY < 0) begin : g_bad
      $error("wcut_flag: quantity %0d needs a negative alignment delay", i);
    end else if (DLY == 0) begin : g_nodly
      assign q_aln[i*W +: W] = q_in[i*W +: W];
    end else begin : g_dly
      wcut_delay_line #(.W(W), .DEPTH(DLY)) u_dly (
        .clk (clk),
        .rst (rst),
        .d   (q_in[i*W +: W]),
        .q   (q_aln[i*W +: W])
      );
    end

    wcut_window_test #(
      .W     (W),
      .NW    (NW),
      .SCALE (int'(SCALE[i*LIM_W +: LIM_W])),
      .EN    (WIN_EN[i*NW +: NW]),
      .LO    (LO_PHYS[i*NW*LIM_W +: NW*LIM_W]),
      .HI    (HI_PHYS[i*NW*LIM_W +: NW*LIM_W])
    ) u_win (
      .val  (q_aln[i*W +: W]),
      .pass (q_pass[i])
    );
  end

  assign flag_o = &q_pass;
endmodule

// File: rtl/wcut_flag_chk.sv
module wcut_flag_chk
  import wcut_pkg::*;
#(
  parameter int                  NQ         = 3,
  parameter int                  NW         = 2,
  parameter int                  W          = 12,
  parameter int                  FLAG_STAGE = 4,
  parameter logic [NQ*8-1:0]     SRC_STAGE  = '0,
  parameter logic [NQ-1:0]       Q_CONST    = '0,
  parameter logic [NQ*32-1:0]    SCALE      = '0,
  parameter logic [NQ*NW-1:0]    WIN_EN     = '0,
  parameter logic [NQ*NW*32-1:0] LO_PHYS    = '0,
  parameter logic [NQ*NW*32-1:0] HI_PHYS    = '0
) (
  input logic            clk,
  input logic            rst,
  input logic [NQ*W-1:0] q_in,
  input logic [NQ*W-1:0] q_aln,
  input logic [NQ-1:0]   q_pass,
  input logic            flag_o
);
  function automatic int hull_lo(input int qi);
    int r;
    int b;
    r = 32'h7fffffff;
    for (int w = 0; w < NW; w++) begin
      if (WIN_EN[qi*NW+w]) begin
        b = native_bound($signed(LO_PHYS[(qi*NW+w)*LIM_W +: LIM_W]), int'(SCALE[qi*LIM_W +: LIM_W]));
        if (b < r) r = b;
      end
    end
    return r;
  endfunction

  function automatic int hull_hi(input int qi);
    int r;
    int b;
    r = 32'h80000000;
    for (int w = 0; w < NW; w++) begin
      if (WIN_EN[qi*NW+w]) begin
        b = native_bound($signed(HI_PHYS[(qi*NW+w)*LIM_W +: LIM_W]), int'(SCALE[qi*LIM_W +: LIM_W]));
        if (b > r) r = b;
      end
    end
    return r;
  endfunction

  for (genvar i = 0; i < NQ; i++) begin : g_c
    localparam int DLY = FLAG_STAGE - int'(SRC_STAGE[i*STAGE_W +: STAGE_W]);
    localparam int HLO = hull_lo(i);
    localparam int HHI = hull_hi(i);

    if (Q_CONST[i]) begin : g_k
      AST_CONST_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
        q_aln[i*W +: W] == q_in[i*W +: W]); // R6
    end else if (DLY > 0) begin : g_d
      logic [W-1:0] mdl [DLY];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int k = 0; k < DLY; k++) mdl[k] <= '0;
        end else begin
          mdl[0] <= q_in[i*W +: W];
          for (int k = 1; k < DLY; k++) mdl[k] <= mdl[k-1];
        end
      end
      AST_ALIGN_DEPTH: assert property (@(posedge clk) disable iff (rst)
        q_aln[i*W +: W] == mdl[DLY-1]); // R5
      AST_RESET_CLEARS: assert property (@(posedge clk)
        $past(rst) |-> q_aln[i*W +: W] == mdl[DLY-1]); // R8
    end

    AST_PASS_IN_HULL: assert property (@(posedge clk) disable iff (rst)
      q_pass[i] |-> ($signed(q_aln[i*W +: W]) > HLO) && ($signed(q_aln[i*W +: W]) < HHI)); // R1
    AST_FLAG_NEEDS_HULL: assert property (@(posedge clk) disable iff (rst)
      flag_o |-> ($signed(q_aln[i*W +: W]) > HLO) && ($signed(q_aln[i*W +: W]) < HHI)); // R4
  end

  AST_FLAG_KNOWN: assert property (@(posedge clk) disable iff (rst)
    !$isunknown(flag_o)); // R7
endmodule

bind wcut_flag wcut_flag_chk #(
  .NQ(NQ), .NW(NW), .W(W), .FLAG_STAGE(FLAG_STAGE), .SRC_STAGE(SRC_STAGE),
  .Q_CONST(Q_CONST), .SCALE(SCALE), .WIN_EN(WIN_EN), .LO_PHYS(LO_PHYS), .HI_PHYS(HI_PHYS)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .q_in   (q_in),
  .q_aln  (q_aln),
  .q_pass (q_pass),
  .flag_o (flag_o)
);

// File: tb/wcut_flag_tb.sv
module wcut_flag_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [35:0] q_in = '0;
  logic        flag_o;

  int vectors = 0;
  int miscompares = 0;

  // bench history: value of quantity 0 at the last three edges, quantity 1 at the last edge
  logic signed [11:0] h0_0 = '0, h0_1 = '0, h0_2 = '0, h1 = '0, cur2 = '0;

  always #5 clk = ~clk;

  wcut_flag u_dut (.clk(clk), .rst(rst), .q_in(q_in), .flag_o(flag_o));

  function automatic bit ok0(input logic signed [11:0] v);
    return (v > -100 && v < 100) || (v > 250 && v < 300);
  endfunction
  function automatic bit ok1(input logic signed [11:0] v);
    return v > -33 && v < 66;
  endfunction
  function automatic bit ok2(input logic signed [11:0] v);
    return v > 0 && v < 50;
  endfunction

  task automatic check(input string tag, input bit exp);
    vectors++;
    if (flag_o !== exp) begin
      miscompares++;
      $display("FAIL %s flag_o=%b expected=%b", tag, flag_o, exp);
    end
  endtask

  task automatic apply(input logic signed [11:0] a, input logic signed [11:0] b,
                       input logic signed [11:0] c, input string tag);
    @(negedge clk);
    q_in = {c, b, a};
    cur2 = c;
    @(posedge clk);
    h0_2 = h0_1;
    h0_1 = h0_0;
    h0_0 = rst ? 12'sd0 : a;
    h1   = rst ? 12'sd0 : b;
    #2;
    check(tag, ok0(h0_2) && ok1(h1) && ok2(cur2));
  endtask

  task automatic t_reset();
    rst = 1'b1;
    apply(12'sd0, 12'sd0, 12'sd10, "R8 reset zero state");
    apply(12'sd500, 12'sd500, 12'sd10, "R8 inputs ignored in reset");
    apply(12'sd500, 12'sd500, 12'sd10, "R8 inputs ignored in reset");
    apply(12'sd0, 12'sd0, 12'sd0, "R8 reset with q2 on limit");
    rst = 1'b0;
    for (int k = 0; k < 4; k++) apply(12'sd0, 12'sd0, 12'sd10, "R8 after release");
  endtask

  task automatic t_limits_q1();
    apply(12'sd0, -12'sd33, 12'sd10, "R2 q1 truncated lower equal");
    apply(12'sd0, -12'sd32, 12'sd10, "R1 q1 just inside low");
    apply(12'sd0, 12'sd65, 12'sd10, "R1 q1 just inside high");
    apply(12'sd0, 12'sd66, 12'sd10, "R2 q1 truncated upper equal");
    apply(12'sd0, 12'sd100, 12'sd10, "R3 q1 disabled window");
  endtask

  task automatic t_limits_q0();
    apply(-12'sd100, 12'sd0, 12'sd10, "R1 q0 lower limit");
    apply(-12'sd99, 12'sd0, 12'sd10, "R1 q0 inside low");
    apply(12'sd99, 12'sd0, 12'sd10, "R1 q0 inside high");
    apply(12'sd100, 12'sd0, 12'sd10, "R1 q0 upper limit");
    apply(12'sd250, 12'sd0, 12'sd10, "R3 q0 second window low edge");
    apply(12'sd251, 12'sd0, 12'sd10, "R3 q0 second window");
    apply(12'sd299, 12'sd0, 12'sd10, "R2 q0 second window top");
    apply(12'sd300, 12'sd0, 12'sd10, "R2 q0 second window edge");
    apply(12'sd150, 12'sd0, 12'sd10, "R3 q0 between windows");
    for (int k = 0; k < 3; k++) apply(12'sd0, 12'sd0, 12'sd10, "R3 drain");
  endtask

  task automatic t_and();
    apply(12'sd0, 12'sd0, 12'sd10, "R4 all pass");
    apply(12'sd0, 12'sd70, 12'sd10, "R4 q1 fails");
    apply(12'sd0, 12'sd0, 12'sd60, "R4 q2 fails");
    apply(12'sd400, 12'sd0, 12'sd10, "R4 q0 fails");
    for (int k = 0; k < 3; k++) apply(12'sd0, 12'sd0, 12'sd10, "R4 drain");
  endtask

  task automatic t_align();
    apply(12'sd500, 12'sd0, 12'sd10, "R5 q0 pulse enters");
    for (int k = 0; k < 4; k++) apply(12'sd0, 12'sd0, 12'sd10, "R5 q0 pulse three cycles late");
    apply(12'sd0, 12'sd500, 12'sd10, "R5 q1 pulse one cycle");
    apply(12'sd0, 12'sd0, 12'sd10, "R5 q1 pulse gone");
  endtask

  task automatic t_const();
    apply(12'sd0, 12'sd0, 12'sd0, "R6 q2 at lower limit now");
    apply(12'sd0, 12'sd0, 12'sd49, "R6 q2 inside now");
    apply(12'sd0, 12'sd0, 12'sd50, "R6 q2 at upper limit now");
    apply(12'sd0, 12'sd0, 12'sd1, "R6 q2 inside low");
  endtask

  task automatic t_comb();
    apply(12'sd0, 12'sd0, 12'sd10, "R7 baseline");
    q_in[35:24] = 12'sd60;
    #1;
    check("R7 no edge, q2 out", 1'b0);
    q_in[35:24] = 12'sd20;
    #1;
    check("R7 no edge, q2 back in", 1'b1);
    cur2 = 12'sd20;
  endtask

  task automatic t_random();
    for (int k = 0; k < 300; k++) begin
      apply(12'($signed($urandom_range(800)) - 400),
            12'($signed($urandom_range(200)) - 100),
            12'($signed($urandom_range(80)) - 10), "R4 random mix");
    end
  endtask

  initial begin
    t_reset();
    t_limits_q1();
    t_limits_q0();
    t_and();
    t_align();
    t_const();
    t_comb();
    t_random();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #1000000;
    miscompares++;
    $display("FAIL watchdog expired, run did not complete");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule